// File: doc/BRIEF.md
# Serial Channel Control Slave

This block is a serial-peripheral slave that owns the on/off controls of eight load channels. A host lowers chip-select, clocks a frame in most-significant bit first, and raises chip-select; the block then copies the last received byte into a latched control word. In the same frame the block returns one status bit per channel. The status word is captured in parallel when chip-select falls.

All four serial pins are sampled by a fast system clock through synchronisers, and the serial-clock edges are found inside the block. A frame is accepted only when the number of serial-clock falling edges is a non-zero multiple of the channel count. Longer frames flow through the shift register and appear again at the data output, so several slaves can share one chip-select in a chain. The control word and the status word are plain level buses: the channel logic reads the control word at any time and drives the status word continuously, with no valid/ready handshake and no back-pressure.

A control bit of 1 switches its channel off. A functional reset comes either from the active-low reset pin or from the active-high undervoltage input. It turns every channel off and does not touch the data-output pin.

Top module: `spi_chan_ctrl`

## Requirements
- R1: Serial input is sampled on each serial-clock falling edge while chip-select is low. It enters at bit 0 of the shift register and moves toward bit 7, so the first of the last eight bits lands on control bit 7 and the last lands on control bit 0.
- R2: Control bit n drives channel n. The value 1 means off and 0 means on. After power-on reset the control word is all ones.
- R3: On a chip-select falling edge the 8-bit status word is loaded into the shift register, and the data output presents status bit 7. At each later serial-clock rising edge the data output takes the shift register's bit 7, so the status bits leave in the order 7 down to 0.
- R4: On a chip-select rising edge the shift register is copied to the control word only if the falling serial-clock edges counted since the last chip-select fall number 8, 16, 24 and so on. With 0 edges, or with any count that is not a multiple of 8, the control word keeps its value.
- R5: After the eighth bit of a frame, the data output repeats the bits received eight positions earlier, in the order they arrived.
- R6: While chip-select is high, serial-clock and data-in activity has no effect, and the output-enable is low.
- R7: While the reset pin is low or the undervoltage input is high, the control word is all ones, and the shift register and edge counter are cleared.
- R8: A functional reset does not change the output-enable. It stays high while chip-select is low.
- R9: The control word changes only in the cycle after a detected chip-select rise or during a functional reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Functional reset pin, active low |
| uv_rst | input | 1 | Undervoltage reset, active high |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output-enable for the data-out pad |
| stat_i | input | 8 | Per-channel status from the channel logic |
| ctrl_q | output | 8 | Latched per-channel control, 1 = off |

## Verification
The bench builds the block with eight channels and two synchroniser stages. With eight channels the 3-bit edge counter wraps within a single byte, so frames of 0, 5, 8, 12 and 16 edges all fit in a short run. These frames cover the multiple-of-8 rule on both sides, as well as the pass-through seen in a two-slave chain. With two stages, a serial half-period of eight system cycles leaves enough margin for every edge to be seen before the bench samples.

// File: rtl/scc_pkg.sv
package scc_pkg;
  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic sck_fall;
    logic sck_rise;
  } scc_evt_t;
endpackage

// File: rtl/scc_sync.sv
module scc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge por_n)
        if (!por_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge por_n)
        if (!por_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scc_edges.sv
module scc_edges
  import scc_pkg::*;
(
  input  logic     clk,
  input  logic     por_n,
  input  logic     cs_s,
  input  logic     sck_s,
  output scc_evt_t evt
);
  logic cs_d, sck_d;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end

  // Serial-clock edges count only while the slave is selected.
  always_comb begin
    evt.cs_fall  = cs_d & ~cs_s;
    evt.cs_rise  = ~cs_d & cs_s;
    evt.sck_fall = ~cs_s & sck_d & ~sck_s;
    evt.sck_rise = ~cs_s & ~sck_d & sck_s;
  end
endmodule

// File: rtl/scc_frame.sv
module scc_frame
  import scc_pkg::*;
#(
  parameter int W = 8,
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          frst,
  input  scc_evt_t      evt,
  input  logic          mosi_s,
  input  logic [W-1:0]  stat_i,
  output logic [W-1:0]  sr,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic [W-1:0]  ctrl,
  output logic          miso_q
);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      sr   <= '0;
      cnt  <= '0;
      full <= 1'b0;
      ctrl <= '1;
    end else if (frst) begin
      sr   <= '0;
      cnt  <= '0;
      full <= 1'b0;
      ctrl <= '1;
    end else if (evt.cs_fall) begin
      sr   <= stat_i;
      cnt  <= '0;
      full <= 1'b0;
    end else if (evt.cs_rise) begin
      if (full && cnt == '0) ctrl <= sr;
    end else if (evt.sck_fall) begin
      sr  <= {sr[W-2:0], mosi_s};
      cnt <= cnt + CW'(1);
      if (cnt == LAST) full <= 1'b1;
    end

  // The data-out bit ignores the functional reset.
  always_ff @(posedge clk or negedge por_n)
    if (!por_n)            miso_q <= 1'b0;
    else if (evt.cs_fall)  miso_q <= stat_i[W-1];
    else if (evt.sck_rise) miso_q <= sr[W-1];
endmodule

// File: rtl/spi_chan_ctrl.sv
module spi_chan_ctrl
  import scc_pkg::*;
#(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         rst_n,
  input  logic         uv_rst,
  input  logic         cs_n,
  input  logic         sck,
  input  logic         mosi,
  output logic         miso,
  output logic         miso_oe,
  input  logic [W-1:0] stat_i,
  output logic [W-1:0] ctrl_q
);
  logic          cs_s, sck_s, mosi_s, rst_s, uv_s, frst;
  scc_evt_t      evt;
  logic [W-1:0]  sr;
  logic [CW-1:0] cnt;
  logic          full;

  // Reset values: deselected, clock low, data low, reset asserted.
  scc_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b10001)) u_sync (
    .clk(clk), .por_n(por_n),
    .d({cs_n, sck, mosi, rst_n, uv_rst}),
    .q({cs_s, sck_s, mosi_s, rst_s, uv_s})
  );

  assign frst = ~rst_s | uv_s;

  scc_edges u_edges (
    .clk(clk), .por_n(por_n), .cs_s(cs_s), .sck_s(sck_s), .evt(evt)
  );

  scc_frame #(.W(W)) u_frame (
    .clk(clk), .por_n(por_n), .frst(frst), .evt(evt), .mosi_s(mosi_s),
    .stat_i(stat_i), .sr(sr), .cnt(cnt), .full(full), .ctrl(ctrl_q),
    .miso_q(miso)
  );

  assign miso_oe = ~cs_s;
endmodule

// File: rtl/scc_checker.sv
module scc_checker
  import scc_pkg::*;
#(
  parameter int W = 8,
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input logic          clk,
  input logic          por_n,
  input logic          frst,
  input logic          cs_s,
  input scc_evt_t      evt,
  input logic [W-1:0]  sr,
  input logic [CW-1:0] cnt,
  input logic          full,
  input logic [W-1:0]  ctrl_q,
  input logic          miso
);
  // R9: the control word is stable unless a chip-select rise or a reset came first
  p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
    (!evt.cs_rise && !frst) |=> $stable(ctrl_q));

  // R7: a functional reset forces every channel off
  p_rst_off_r7: assert property (@(posedge clk) disable iff (!por_n)
    frst |=> (ctrl_q == '1 && sr == '0 && cnt == '0));

  // R4: a well-formed frame copies the shift register into the control word
  p_update_r4: assert property (@(posedge clk) disable iff (!por_n)
    (evt.cs_rise && !frst && full && cnt == '0) |=> ctrl_q == $past(sr));

  // R4: each frame starts its edge count afresh
  p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!por_n)
    (evt.cs_fall && !frst) |=> (cnt == '0 && !full));

  // R6: while deselected the shift register does not move
  p_ignore_r6: assert property (@(posedge clk) disable iff (!por_n)
    (cs_s && !frst) |=> $stable(sr));

  // R3: data out moves only on a serial-clock rise or a chip-select fall
  p_miso_r3: assert property (@(posedge clk) disable iff (!por_n)
    (!evt.sck_rise && !evt.cs_fall) |=> $stable(miso));
endmodule

bind spi_chan_ctrl scc_checker #(.W(W)) u_chk (
  .clk(clk), .por_n(por_n), .frst(frst), .cs_s(cs_s), .evt(evt), .sr(sr),
  .cnt(cnt), .full(full), .ctrl_q(ctrl_q), .miso(miso)
);

// File: tb/sim_spi_chan_ctrl.sv
module sim_spi_chan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NV = 7;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, uv_rst = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;
  logic [7:0] stat_i = '0, ctrl_q;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_chan_ctrl #(.W(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .uv_rst(uv_rst), .cs_n(cs_n),
    .sck(sck), .mosi(mosi), .miso(miso), .miso_oe(miso_oe),
    .stat_i(stat_i), .ctrl_q(ctrl_q)
  );

  // {edge count[4:0], sent bits[15:0], status[7:0], expected control[7:0]}
  localparam logic [36:0] VEC [NV] = '{
    {5'd8,  16'h00A5, 8'h3C, 8'hA5},  // R1 R2
    {5'd8,  16'h0000, 8'hFF, 8'h00},  // R2 all on
    {5'd5,  16'h0015, 8'h96, 8'h00},  // R4 short frame
    {5'd16, 16'h12F0, 8'h5A, 8'hF0},  // R4 R5 two-slave chain
    {5'd0,  16'h0000, 8'h0F, 8'hF0},  // R4 empty frame
    {5'd12, 16'h0ABC, 8'hC3, 8'hF0},  // R4 non-multiple
    {5'd8,  16'h0081, 8'hE7, 8'h81}   // R1
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_stream(input int n, input logic [15:0] tx,
                                             input logic [7:0] st);
    logic [15:0] e = '0;
    for (int k = 0; k < n; k++)
      e = {e[14:0], (k < 8) ? st[7-k] : tx[n-1-(k-8)]};
    return e;
  endfunction

  // Full frame: select, n clocks, deselect. Collects data out during each high phase.
  task automatic frame(input int n, input logic [15:0] tx, input logic [7:0] st,
                       output logic [15:0] got, output logic oe_low_seen);
    got = '0;
    oe_low_seen = 1'b0;
    stat_i = st;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int k = 0; k < n; k++) begin
      mosi = tx[n-1-k];
      sck = 1'b1;
      wait_clk(HALF);
      got = {got[14:0], miso};
      if (!miso_oe) oe_low_seen = 1'b1;
      sck = 1'b0;
      wait_clk(HALF);
    end
    cs_n = 1'b1;
    wait_clk(HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] got;
    logic oe_low;
    wait_clk(4);
    por_n = 1'b1;
    wait_clk(4);
    chk("R2 reset control all off", 16'(ctrl_q), 16'h00FF);
    chk("R6 output-enable low when deselected", 16'(miso_oe), 16'h0000);
    rst_n = 1'b1;
    wait_clk(HALF);

    for (int i = 0; i < NV; i++) begin
      int n;
      n = int'(VEC[i][36:32]);
      frame(n, VEC[i][31:16], VEC[i][15:8], got, oe_low);
      chk($sformatf("R4 R1 control after vector %0d", i), 16'(ctrl_q), 16'(VEC[i][7:0]));
      chk($sformatf("R6 output-enable after vector %0d", i), 16'(miso_oe), 16'h0000);
      if (n > 0) begin
        chk($sformatf("R3 R5 data out stream vector %0d", i), got,
            exp_stream(n, VEC[i][31:16], VEC[i][15:8]));
        chk($sformatf("R8 output-enable during vector %0d", i), 16'(oe_low), 16'h0000);
      end
    end

    // R6: clock and data while deselected are ignored
    for (int k = 0; k < 8; k++) begin
      mosi = k[0];
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
      wait_clk(HALF);
    end
    chk("R6 control unchanged by deselected clocks", 16'(ctrl_q), 16'h0081);
    chk("R6 output-enable stays low", 16'(miso_oe), 16'h0000);
    frame(0, 16'h0, 8'h11, got, oe_low);
    chk("R6 empty frame after deselected clocks keeps control", 16'(ctrl_q), 16'h0081);

    // R7 R8: functional reset while selected
    cs_n = 1'b0;
    wait_clk(HALF);
    rst_n = 1'b0;
    wait_clk(HALF);
    chk("R7 reset pin forces all off", 16'(ctrl_q), 16'h00FF);
    chk("R8 output-enable kept under reset", 16'(miso_oe), 16'h0001);
    rst_n = 1'b1;
    wait_clk(HALF);
    for (int k = 0; k < 8; k++) begin
      mosi = k[1];
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
      wait_clk(HALF);
    end
    cs_n = 1'b1;
    wait_clk(HALF);
    chk("R7 R4 count restarts after reset", 16'(ctrl_q), 16'h0033);

    // R7: undervoltage input
    uv_rst = 1'b1;
    wait_clk(HALF);
    chk("R7 undervoltage forces all off", 16'(ctrl_q), 16'h00FF);
    uv_rst = 1'b0;
    wait_clk(HALF);
    frame(8, 16'h00C3, 8'h24, got, oe_low);
    chk("R1 control after undervoltage release", 16'(ctrl_q), 16'h00C3);
    chk("R3 status after undervoltage release", got, 16'h0024);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule